// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block builds one deep first-in first-out buffer out of several identical segments, each with its own small storage array. Ownership of writing and of reading moves around a ring of segments as two tokens. The segment holding the write token accepts incoming words. The segment holding the read token supplies outgoing words. When a segment stores a word into its last physical location, it pulses its write hand-off output. The next segment in the ring then owns the write token from the following clock edge, and its write pointer starts again at location zero. The read token moves the same way when a segment reads its last location. The last segment hands both tokens back to the first.

One segment is marked as the starting segment by a per-segment first-load select, tied off inside the wrapper. After reset it alone holds both tokens. Outside the block there is a single write port, a single read port, and active-low composite empty and full flags. Composite full is reported when the write-token holder is full. Composite empty is reported when the read-token holder is empty. Only the read-token holder places its head word on the shared read path. One clock drives both ports, and a write and a read may be accepted in the same cycle.

Top module: `fifo_ring_top`

## Requirements
- R1: While reset is high and on the cycle after it, `empty_n` is 0, `full_n` is 1 and `rd_data` is 0.
- R2: Words leave in the order they were written, including across segment boundaries and over several laps of the ring.
- R3: `full_n` is 0 exactly when SEG_COUNT*SEG_DEPTH words are stored. A write presented while `full_n` is 0 stores nothing, and no segment ever holds more than SEG_DEPTH words.
- R4: A read presented while `empty_n` is 0 is ignored: `rd_data` keeps its previous value and the occupancy is unchanged.
- R5: An accepted read (`rd_en`=1 and `empty_n`=1) loads the oldest word into `rd_data` on that clock edge. `rd_data` holds its value in every cycle without an accepted read.
- R6: At every cycle after reset, exactly one segment holds the write token and exactly one holds the read token. After reset the first-load segment holds both.
- R7: A segment that writes (reads) its last location passes the write (read) token. The next segment in the ring, wrapping from the last to the first, owns it on the next clock edge.
- R8: When a write and a read are presented in the same cycle, each is accepted according to the flags of that cycle. Both are accepted when the buffer is neither empty nor full. Only the read is accepted when it is full. Only the write is accepted when it is empty.
- R9: `empty_n` is 0 exactly when no word is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| empty_n | output | 1 | Composite empty flag, low when empty |
| full_n | output | 1 | Composite full flag, low when full |

## Verification
A write and a read can land in the same cycle. This also happens on the very edge where one segment gives up a token while another receives one. The case is provoked by random phases that request both operations with high probability, and by directed cycles that request both at the full and at the empty boundary. Each cycle is judged against a queue model in the bench: that model decides which operation is accepted from the flags it predicts for that cycle, then checks the word and both flags on the falling edge after the clock.

// File: rtl/fifo_ring_pkg.sv
package fifo_ring_pkg;

    // Token ownership held by one segment.
    typedef struct packed {
        logic wr_tok;
        logic rd_tok;
    } seg_tokens_t;

    // Pointer width for a storage array of the given depth.
    function automatic int ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Index of the ring neighbour that feeds segment idx.
    function automatic int ring_prev(input int idx, input int count);
        return (idx + count - 1) % count;
    endfunction

endpackage

// File: rtl/fifo_ring_segment.sv
module fifo_ring_segment
    import fifo_ring_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              first_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              wr_tok_in,
    input  logic              rd_tok_in,
    output logic              wr_tok_out,
    output logic              rd_tok_out,
    output logic              full_n,
    output logic              empty_n,
    output logic              owns_wr,
    output logic              owns_rd,
    output logic [DATA_W-1:0] head_data
);
    localparam int PW = ptr_bits(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_LOC = PW'(DEPTH - 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PW-1:0]     wptr, rptr;
    logic [CW-1:0]     fill;
    seg_tokens_t       tok;
    logic              seg_full, seg_empty, wr_fire, rd_fire;

    assign seg_full   = (fill == CW'(DEPTH));
    assign seg_empty  = (fill == '0);
    assign wr_fire    = wr_en & tok.wr_tok & ~seg_full;
    assign rd_fire    = rd_en & tok.rd_tok & ~seg_empty;
    assign wr_tok_out = wr_fire & (wptr == LAST_LOC);
    assign rd_tok_out = rd_fire & (rptr == LAST_LOC);

    assign full_n    = ~(tok.wr_tok & seg_full);
    assign empty_n   = ~(tok.rd_tok & seg_empty);
    assign owns_wr   = tok.wr_tok;
    assign owns_rd   = tok.rd_tok;
    assign head_data = tok.rd_tok ? store[rptr] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            tok  <= '{wr_tok: first_sel, rd_tok: first_sel};
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            tok.wr_tok <= wr_tok_in | (tok.wr_tok & ~wr_tok_out);
            tok.rd_tok <= rd_tok_in | (tok.rd_tok & ~rd_tok_out);
            if (wr_tok_out || wr_tok_in) wptr <= '0;
            else if (wr_fire)            wptr <= wptr + 1'b1;
            if (rd_tok_out || rd_tok_in) rptr <= '0;
            else if (rd_fire)            rptr <= rptr + 1'b1;
            fill <= fill + CW'(wr_fire) - CW'(rd_fire);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_fire) store[wptr] <= wr_data;
    end

    // R3: a segment never holds more than its depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    // R7: an incoming write hand-off yields ownership on the next edge
    assert_wr_take_R7: assert property (@(posedge clk) disable iff (rst)
        wr_tok_in |=> owns_wr);

    // R7: an outgoing read hand-off (not looped back) releases ownership
    assert_rd_release_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_tok_out && !rd_tok_in) |=> !owns_rd);

endmodule

// File: rtl/fifo_ring_merge.sv
module fifo_ring_merge #(
    parameter int DATA_W    = 18,
    parameter int SEG_COUNT = 3
) (
    input  logic [SEG_COUNT-1:0]             seg_full_n,
    input  logic [SEG_COUNT-1:0]             seg_empty_n,
    input  logic [SEG_COUNT-1:0][DATA_W-1:0] seg_head,
    output logic                             full_n,
    output logic                             empty_n,
    output logic [DATA_W-1:0]                head
);
    // Each segment qualifies its flags by token ownership, so a plain
    // AND of the active-low flags yields the holder's state.
    assign full_n  = &seg_full_n;
    assign empty_n = &seg_empty_n;

    always_comb begin
        head = '0;
        for (int i = 0; i < SEG_COUNT; i++) head = head | seg_head[i];
    end
endmodule

// File: rtl/fifo_ring_top.sv
module fifo_ring_top
    import fifo_ring_pkg::*;
#(
    parameter int DATA_W    = 18,
    parameter int SEG_DEPTH = 8,
    parameter int SEG_COUNT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              full_n
);
    logic [SEG_COUNT-1:0]             wxo, rxo, wxi, rxi;
    logic [SEG_COUNT-1:0]             s_full_n, s_empty_n, s_wtok, s_rtok;
    logic [SEG_COUNT-1:0][DATA_W-1:0] s_head;
    logic [DATA_W-1:0]                head;

    for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
        localparam int PREV = ring_prev(i, SEG_COUNT);
        assign wxi[i] = wxo[PREV];
        assign rxi[i] = rxo[PREV];

        fifo_ring_segment #(.DATA_W(DATA_W), .DEPTH(SEG_DEPTH)) i_seg (
            .clk        (clk),
            .rst        (rst),
            .first_sel  (1'(i == 0)),
            .wr_en      (wr_en),
            .wr_data    (wr_data),
            .rd_en      (rd_en),
            .wr_tok_in  (wxi[i]),
            .rd_tok_in  (rxi[i]),
            .wr_tok_out (wxo[i]),
            .rd_tok_out (rxo[i]),
            .full_n     (s_full_n[i]),
            .empty_n    (s_empty_n[i]),
            .owns_wr    (s_wtok[i]),
            .owns_rd    (s_rtok[i]),
            .head_data  (s_head[i])
        );
    end

    fifo_ring_merge #(.DATA_W(DATA_W), .SEG_COUNT(SEG_COUNT)) i_merge (
        .seg_full_n  (s_full_n),
        .seg_empty_n (s_empty_n),
        .seg_head    (s_head),
        .full_n      (full_n),
        .empty_n     (empty_n),
        .head        (head)
    );

    always_ff @(posedge clk) begin
        if (rst)                    rd_data <= '0;
        else if (rd_en && empty_n)  rd_data <= head;
    end

    // R6: exactly one write-token and one read-token owner
    assert_wr_tok_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot(s_wtok));
    assert_rd_tok_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot(s_rtok));

    // R1: reset leaves the buffer empty and not full
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!empty_n && full_n && rd_data == '0));

    // R4: a read while empty leaves the output untouched
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && rd_en) |=> $stable(rd_data));

    // R3: while full, no hand-off of the write token can occur
    assert_full_no_wr_R3: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> (wxo == '0));

endmodule

// File: tb/test_fifo_ring_top.sv
module test_fifo_ring_top;
    localparam int DW  = 18;
    localparam int SD  = 8;
    localparam int SC  = 3;
    localparam int CAP = SD * SC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          empty_n, full_n;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [DW-1:0] model_q[$];
    logic [DW-1:0] exp_rd = '0;

    always #2.5 clk = ~clk;

    fifo_ring_top #(.DATA_W(DW), .SEG_DEPTH(SD), .SEG_COUNT(SC)) i_fifo_ring_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n)
    );

    function automatic logic exp_empty_n(input int n);
        return n != 0;
    endfunction
    function automatic logic exp_full_n(input int n);
        return n != CAP;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Starts and ends at a falling edge.
    task automatic step(input bit w, input bit r, input logic [DW-1:0] d, input string tag);
        bit wacc, racc;
        int n = model_q.size();
        check(empty_n == exp_empty_n(n), {tag, " R9 empty_n"}, empty_n, exp_empty_n(n));
        check(full_n == exp_full_n(n), {tag, " R3 full_n"}, full_n, exp_full_n(n));
        wacc = w && (n != CAP);
        racc = r && (n != 0);
        wr_en = w; rd_en = r; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        if (racc) exp_rd = model_q.pop_front();
        if (wacc) model_q.push_back(d);
        check(rd_data == exp_rd, {tag, " R2 R5 rd_data"}, rd_data, exp_rd);
        wr_en = 0; rd_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R2 actual=hang expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state during reset
        check(empty_n == 1'b0, "R1 empty_n in reset", empty_n, 0);
        check(full_n == 1'b1, "R1 full_n in reset", full_n, 1);
        check(rd_data == '0, "R1 rd_data in reset", rd_data, 0);
        rst = 0;
        @(negedge clk);
        check(empty_n == 1'b0, "R1 empty_n after reset", empty_n, 0);
        check(rd_data == '0, "R1 rd_data after reset", rd_data, 0);

        // R4: read while empty ignored; R8 read+write while empty
        step(0, 1, 18'h0, "R4 empty read");
        step(1, 1, 18'h11, "R8 rw at empty");
        step(0, 1, 18'h0, "R8 drain one");
        step(0, 1, 18'h0, "R4 empty read again");

        // R3 R7: fill completely, crossing every segment boundary
        for (int i = 0; i < CAP; i++) step(1, 0, DW'(18'h100 + i), "R7 fill");
        step(1, 0, 18'h3ffff, "R3 write while full");
        step(1, 1, 18'h2aaaa, "R8 rw at full");
        step(1, 0, 18'h00777, "R3 refill last");
        for (int i = 0; i < CAP + 2; i++) step(0, 1, 18'h0, "R2 drain");
        check(empty_n == 1'b0, "R9 empty after drain", empty_n, 0);

        // R2 R6 R7 R8: random phases over many laps of the ring
        for (int ph = 0; ph < 16; ph++) begin
            int pw = 20 + ($urandom % 70);
            int pr = 20 + ($urandom % 70);
            for (int c = 0; c < 250; c++) begin
                bit w = ($urandom % 100) < pw;
                bit r = ($urandom % 100) < pr;
                step(w, r, DW'($urandom), "R8 random");
            end
        end
        while (model_q.size() != 0) step(0, 1, 18'h0, "R2 final drain");
        step(0, 1, 18'h0, "R4 final empty read");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule